// File: doc/BRIEF.md
# Receive Packet Framer with CRC-16 Check

This block sits behind a demodulator and clock-recovery stage. It turns a serial bit stream into stored packet payload. It receives one bit at a time, qualified by a valid strobe, with the most significant bit of each byte first. It then walks a fixed framing sequence:

1. It waits for a run of alternating bits (the `0x55` training pattern). The length of this run is configurable, and the wait can be skipped entirely.
2. It searches for a programmable sync pattern of one to four bytes.
3. It accepts either a fixed number of payload bytes, or a length byte followed by that many payload bytes.
4. It compares a trailing 16-bit check value against a CRC it computes while the bytes arrive.

Payload bytes are written into an on-block FIFO that a host drains through a show-ahead read port. At the end of every packet the block raises a single-cycle pulse: one output for a matching check value, another for a mismatching one.

The CRC has these properties:

- Generator polynomial: x^16 + x^15 + x^2 + 1.
- Start value: all ones.
- Processing: one bit per clock, most significant bit first.
- Final XOR: none.
- Coverage: the length byte, when present, and every payload byte.

The received check value is also sent most significant bit first.

Top module: `rx_pkt_framer`

## Requirements
- R1: After reset the FIFO is empty (`fifo_count` 0, `fifo_empty` 1), `ovf_flag` is 0 and neither end-of-packet pulse is high.
- R2: With `cfg_pre_en` high, the sync search starts only after `cfg_pre_bytes`×8 consecutive alternating valid bits. A shorter run followed by a correct sync word and payload produces no FIFO write and no pulse.
- R3: Two equal consecutive valid bits during the training search restart the alternating-bit count at 1.
- R4: With `cfg_pre_en` low, the block hunts for the sync word directly, and a packet with no training bits at all is received.
- R5: The sync word has `cfg_sync_len`+1 bytes (encoding 0..3 for 1..4 bytes). It is compared against the low bytes of `cfg_sync_word`, with the last received byte in bits [7:0]. Extra training bits before the sync word are tolerated.
- R6: With `cfg_var_len` low, exactly `cfg_fix_len` (1..64) bytes after the sync word are written to the FIFO, and the next 16 bits are the check value.
- R7: With `cfg_var_len` high, the first byte after the sync word gives the payload length. That byte is included in the CRC but is not written to the FIFO.
- R8: A length byte of 0 or above 64 ends the packet at once. Nothing is written, no pulse is raised, and the block returns to the training search.
- R9: When the received check value equals the computed CRC, `pkt_ok` is high for exactly one cycle, starting in the cycle after the clock edge that takes the last check bit.
- R10: On a mismatch, `pkt_crc_err` pulses with the same timing instead of `pkt_ok`. The payload bytes already stored remain in the FIFO.
- R11: A payload byte that arrives while the FIFO holds 64 bytes is discarded. It sets `ovf_flag`, which then stays high until reset. The CRC check still covers the discarded bytes.
- R12: `rd_data` shows the oldest stored byte whenever the FIFO is not empty. `rd_en` removes that byte one cycle later, and `rd_en` on an empty FIFO has no effect.
- R13: Once the sync word is found, the block does not search again until the packet ends. A sync pattern inside the payload is stored as ordinary data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Demodulated data bit |
| bit_vld | input | 1 | `bit_in` holds a new bit this cycle |
| cfg_pre_en | input | 1 | Require the training run before the sync search |
| cfg_pre_bytes | input | 8 | Training run length in bytes (3..255 in use) |
| cfg_sync_len | input | 2 | Sync word length minus one |
| cfg_sync_word | input | 32 | Sync pattern, last received byte in bits [7:0] |
| cfg_var_len | input | 1 | Take the payload length from the first byte after sync |
| cfg_fix_len | input | 7 | Payload length in fixed-length mode (1..64) |
| rd_en | input | 1 | Remove the oldest FIFO byte |
| rd_data | output | 8 | Oldest FIFO byte |
| fifo_empty | output | 1 | FIFO holds no bytes |
| fifo_count | output | 7 | Number of bytes in the FIFO |
| pkt_ok | output | 1 | One-cycle pulse: check value matched |
| pkt_crc_err | output | 1 | One-cycle pulse: check value mismatched |
| ovf_flag | output | 1 | Sticky FIFO overflow indication |

## Verification
Most internal faults in this block cannot be seen until the end of a packet:

- A wrong training count or a wrong sync comparison shows up as a missing or spurious packet. The first visible sign is at the first payload byte written, or at the missing end-of-packet pulse.
- A CRC register that drifts by one bit flips `pkt_ok` into `pkt_crc_err` on the cycle after the last check bit.

A byte counter that is off by one shifts every later byte of the packet and moves the pulse by eight valid bits. For that reason the FIFO occupancy, the head byte, the pulses and the overflow flag are compared against a behavioural model on every clock. This catches such faults on the first cycle they diverge, not only at the end of the packet.

// File: rtl/rx_pkt_framer.sv
module rx_pkt_framer #(
  parameter int DEPTH    = 64,
  parameter int MAX_PRE  = 255,
  parameter int SYNC_MAX = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = $clog2(MAX_PRE + 1),
  localparam int SLW  = (SYNC_MAX > 1) ? $clog2(SYNC_MAX) : 1,
  localparam int SW   = SYNC_MAX * 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_in,
  input  logic          bit_vld,
  input  logic          cfg_pre_en,
  input  logic [PW-1:0] cfg_pre_bytes,
  input  logic [SLW-1:0] cfg_sync_len,
  input  logic [SW-1:0] cfg_sync_word,
  input  logic          cfg_var_len,
  input  logic [LW-1:0] cfg_fix_len,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic          fifo_empty,
  output logic [AW:0]   fifo_count,
  output logic          pkt_ok,
  output logic          pkt_crc_err,
  output logic          ovf_flag
);
  localparam int RUNW = $clog2(MAX_PRE * 8 + 1);
  localparam int SHW  = (SW > 16) ? SW : 16;
  localparam logic [15:0] POLY = 16'h8005;
  localparam logic [7:0] LEN_MAX = 8'(DEPTH);
  localparam logic [RUNW-1:0] RUN_TOP = '1;

  typedef enum logic [2:0] {
    S_PRE  = 3'd0,
    S_SYNC = 3'd1,
    S_LEN  = 3'd2,
    S_PAY  = 3'd3,
    S_CHK  = 3'd4
  } state_t;

  state_t          st;
  logic            last_bit;
  logic [RUNW-1:0] run;
  logic [SHW-1:0]  shreg;
  logic [SHW-1:0]  smask;
  logic [2:0]      bcnt;
  logic [6:0]      bsh;
  logic [3:0]      ccnt;
  logic [15:0]     crc;
  logic [LW-1:0]   remain;
  logic [7:0]      mem [DEPTH];
  logic [AW:0]     wp, rp;

  wire [SHW-1:0]  sh_nx     = {shreg[SHW-2:0], bit_in};
  wire [7:0]      byte_nx   = {bsh, bit_in};
  wire            byte_done = bit_vld && (bcnt == 3'd7);
  wire [RUNW-1:0] run_nx    = (bit_in != last_bit) ?
                              ((run == RUN_TOP) ? run : run + RUNW'(1)) : RUNW'(1);
  wire            pre_hit   = run_nx >= (RUNW'(cfg_pre_bytes) << 3);
  wire            sync_hit  = ((sh_nx ^ SHW'(cfg_sync_word)) & smask) == '0;
  wire [15:0]     crc_nx    = {crc[14:0], 1'b0} ^ ((crc[15] ^ bit_in) ? POLY : 16'h0000);
  wire            len_bad   = (byte_nx == 8'd0) || (byte_nx > LEN_MAX);
  wire            wr_req    = (st == S_PAY) && byte_done;
  wire            full      = fifo_count == (AW+1)'(DEPTH);
  wire            fifo_we   = wr_req && !full;

  assign fifo_count = wp - rp;
  assign fifo_empty = wp == rp;
  assign rd_data    = mem[rp[AW-1:0]];

  always_comb begin
    smask = '0;
    for (int i = 0; i < SYNC_MAX; i++)
      smask[i*8 +: 8] = (SLW'(i) <= cfg_sync_len) ? 8'hFF : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_PRE;
      last_bit    <= 1'b1;
      run         <= '0;
      shreg       <= '0;
      bcnt        <= '0;
      bsh         <= '0;
      ccnt        <= '0;
      crc         <= '1;
      remain      <= '0;
      pkt_ok      <= 1'b0;
      pkt_crc_err <= 1'b0;
    end else begin
      pkt_ok      <= 1'b0;
      pkt_crc_err <= 1'b0;
      if (bit_vld) begin
        shreg    <= sh_nx;
        last_bit <= bit_in;
      end
      case (st)
        S_PRE: begin
          if (!cfg_pre_en) st <= S_SYNC;
          else if (bit_vld) begin
            run <= run_nx;
            if (pre_hit) st <= S_SYNC;
          end
        end
        S_SYNC: begin
          if (bit_vld && sync_hit) begin
            st     <= cfg_var_len ? S_LEN : S_PAY;
            bcnt   <= '0;
            ccnt   <= '0;
            crc    <= '1;
            remain <= cfg_fix_len;
          end
        end
        S_LEN, S_PAY: begin
          if (bit_vld) begin
            crc  <= crc_nx;
            bcnt <= bcnt + 3'd1;
            bsh  <= byte_nx[6:0];
            if (byte_done) begin
              if (st == S_LEN) begin
                if (len_bad) begin
                  st  <= S_PRE;
                  run <= '0;
                end else begin
                  remain <= LW'(byte_nx);
                  st     <= S_PAY;
                end
              end else begin
                remain <= remain - LW'(1);
                if (remain == LW'(1)) st <= S_CHK;
              end
            end
          end
        end
        S_CHK: begin
          if (bit_vld) begin
            ccnt <= ccnt + 4'd1;
            if (ccnt == 4'd15) begin
              pkt_ok      <= sh_nx[15:0] == crc;
              pkt_crc_err <= sh_nx[15:0] != crc;
              st          <= S_PRE;
              run         <= '0;
            end
          end
        end
        default: st <= S_PRE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (fifo_we) wp <= wp + (AW+1)'(1);
      if (rd_en && !fifo_empty) rp <= rp + (AW+1)'(1);
      if (wr_req && full) ovf_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fifo_we) mem[wp[AW-1:0]] <= byte_nx;
  end
endmodule

// File: rtl/rx_pkt_framer_chk.sv
module rx_pkt_framer_chk #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_vld,
  input logic          rd_en,
  input logic          pkt_ok,
  input logic          pkt_crc_err,
  input logic          ovf_flag,
  input logic          fifo_empty,
  input logic          fifo_we,
  input logic [CW-1:0] fifo_count,
  input logic [2:0]    st
);
  localparam logic [2:0] ST_PAYLOAD = 3'd3;

  assert_single_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ok |-> !pkt_crc_err);
  assert_ok_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ok |=> !pkt_ok);
  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_crc_err |=> !pkt_crc_err);
  assert_event_after_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_ok || pkt_crc_err) |-> $past(bit_vld));
  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);
  assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));
  assert_write_in_payload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we |-> st == ST_PAYLOAD);
  assert_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !fifo_empty && !fifo_we) |=> fifo_count == $past(fifo_count) - CW'(1));
  assert_empty_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && !fifo_we) |=> fifo_empty);
endmodule

bind rx_pkt_framer rx_pkt_framer_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .rd_en(rd_en),
  .pkt_ok(pkt_ok), .pkt_crc_err(pkt_crc_err), .ovf_flag(ovf_flag),
  .fifo_empty(fifo_empty), .fifo_we(fifo_we), .fifo_count(fifo_count), .st(st)
);

// File: tb/rx_pkt_framer_tb_top.sv
module rx_pkt_framer_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, bit_in = 1'b0, bit_vld = 1'b0;
  logic        cfg_pre_en = 1'b1, cfg_var_len = 1'b0, rd_en = 1'b0;
  logic [7:0]  cfg_pre_bytes = 8'd4;
  logic [1:0]  cfg_sync_len = 2'd1;
  logic [31:0] cfg_sync_word = 32'h0000_2DD4;
  logic [6:0]  cfg_fix_len = 7'd4;
  logic [7:0]  rd_data;
  logic        fifo_empty, pkt_ok, pkt_crc_err, ovf_flag;
  logic [6:0]  fifo_count;

  rx_pkt_framer dut_i (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .cfg_pre_en(cfg_pre_en), .cfg_pre_bytes(cfg_pre_bytes),
    .cfg_sync_len(cfg_sync_len), .cfg_sync_word(cfg_sync_word),
    .cfg_var_len(cfg_var_len), .cfg_fix_len(cfg_fix_len), .rd_en(rd_en),
    .rd_data(rd_data), .fifo_empty(fifo_empty), .fifo_count(fifo_count),
    .pkt_ok(pkt_ok), .pkt_crc_err(pkt_crc_err), .ovf_flag(ovf_flag)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, gap = 0;
  string req = "R1";
  logic [7:0] mq[$];
  bit e_ok = 0, e_err = 0, e_ovf = 0;
  logic sb[$];
  int sp[$];
  int se[$];
  logic [7:0] pay[$];

  function automatic logic [15:0] crc_byte(logic [15:0] c, logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = c[15] ^ b[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h8005;
    end
    return c;
  endfunction

  task automatic compare();
    logic [7:0] ed;
    bit eempty;
    eempty = (mq.size() == 0);
    ed = eempty ? 8'h00 : mq[0];
    checks++;
    if (pkt_ok !== e_ok || pkt_crc_err !== e_err || fifo_count !== 7'(mq.size()) ||
        fifo_empty !== eempty || ovf_flag !== e_ovf || (!eempty && rd_data !== ed)) begin
      fails++;
      $display("FAIL %s: ok=%0b err=%0b cnt=%0d empty=%0b ovf=%0b data=%02h expected ok=%0b err=%0b cnt=%0d empty=%0b ovf=%0b data=%02h",
               req, pkt_ok, pkt_crc_err, fifo_count, fifo_empty, ovf_flag, rd_data,
               e_ok, e_err, mq.size(), eempty, e_ovf, ed);
    end
  endtask

  task automatic step(bit v, logic b, bit rd, int push, int ev);
    bit full;
    @(negedge clk);
    compare();
    bit_vld = v; bit_in = b; rd_en = rd;
    e_ok = (ev == 1); e_err = (ev == 2);
    full = mq.size() >= 64;
    if (rd && mq.size() > 0) void'(mq.pop_front());
    if (push >= 0) begin
      if (full) e_ovf = 1;
      else mq.push_back(8'(push));
    end
  endtask

  task automatic idle(int n);
    repeat (n) step(0, 1'b0, 0, -1, 0);
  endtask

  task automatic run_stream();
    while (sb.size() > 0) begin
      step(1, sb.pop_front(), 0, sp.pop_front(), se.pop_front());
      gap++;
      if (gap % 3 == 0) step(0, 1'b0, 0, -1, 0);
    end
    idle(3);
  endtask

  task automatic drain();
    while (mq.size() > 0) step(0, 1'b0, 1, -1, 0);
    step(0, 1'b0, 1, -1, 0);
    idle(2);
  endtask

  task automatic put_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sb.push_back(v[i]); sp.push_back(-1); se.push_back(0);
    end
  endtask

  task automatic put_pre(int n);
    repeat (n) put_bits(32'h55, 8);
  endtask

  task automatic fill(int n, int seed);
    pay.delete();
    for (int i = 0; i < n; i++) pay.push_back(8'(seed + i * 37));
  endtask

  task automatic put_frame(int npre, int nsync, logic [31:0] sw, bit vm, bit bad);
    logic [15:0] c;
    c = 16'hFFFF;
    put_pre(npre);
    put_bits(sw, nsync * 8);
    if (vm) begin
      put_bits(32'(pay.size()), 8);
      c = crc_byte(c, 8'(pay.size()));
    end
    foreach (pay[i]) begin
      put_bits(32'(pay[i]), 8);
      sp[sp.size() - 1] = int'(pay[i]);
      c = crc_byte(c, pay[i]);
    end
    if (bad) c = c ^ 16'h0100;
    put_bits(32'(c), 16);
    se[se.size() - 1] = bad ? 2 : 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    req = "R1"; idle(2);

    req = "R6"; fill(4, 8'h11); put_frame(4, 2, 32'h2DD4, 0, 0); run_stream();
    req = "R12"; drain();

    cfg_var_len = 1'b1;
    req = "R7"; fill(5, 3); put_frame(4, 2, 32'h2DD4, 1, 0); run_stream();
    req = "R9"; fill(1, 200); put_frame(5, 2, 32'h2DD4, 1, 0); run_stream(); drain();
    req = "R10"; fill(3, 77); put_frame(4, 2, 32'h2DD4, 1, 1); run_stream(); drain();

    req = "R8";
    put_pre(4); put_bits(32'h2DD4, 16); put_bits(32'h00, 8); run_stream(); idle(4);
    fill(2, 9); put_frame(4, 2, 32'h2DD4, 1, 0); run_stream();
    put_pre(4); put_bits(32'h2DD4, 16); put_bits(32'd65, 8); run_stream(); idle(4);
    fill(3, 21); put_frame(4, 2, 32'h2DD4, 1, 0); run_stream(); drain();
    cfg_var_len = 1'b0;

    req = "R2";
    put_pre(3); put_bits(32'h2DD4, 16); put_bits(32'h0, 32); put_bits(32'hABCD, 16);
    run_stream(); idle(4);
    fill(4, 50); put_frame(4, 2, 32'h2DD4, 0, 0); run_stream(); drain();

    req = "R3";
    put_bits(32'h55, 8); put_bits(32'h55, 8); put_bits(32'h57, 8); put_pre(3);
    put_bits(32'h2DD4, 16); put_bits(32'h0, 32); put_bits(32'h1234, 16);
    run_stream(); idle(4);
    fill(4, 60); put_frame(4, 2, 32'h2DD4, 0, 0); run_stream(); drain();

    req = "R13";
    pay.delete(); pay.push_back(8'h2D); pay.push_back(8'hD4);
    pay.push_back(8'h2D); pay.push_back(8'hD4);
    put_frame(4, 2, 32'h2DD4, 0, 0); run_stream(); drain();

    req = "R5";
    cfg_sync_len = 2'd0; cfg_sync_word = 32'h2D; cfg_fix_len = 7'd3; idle(2);
    fill(3, 100); put_frame(6, 1, 32'h2D, 0, 0); run_stream();
    cfg_sync_len = 2'd2; cfg_sync_word = 32'h2DD4A7; idle(2);
    fill(3, 140); put_frame(4, 3, 32'h2DD4A7, 0, 0); run_stream(); drain();

    req = "R4";
    cfg_pre_en = 1'b0; cfg_sync_len = 2'd3; cfg_sync_word = 32'hA1B2C3D4; cfg_fix_len = 7'd2;
    idle(3);
    fill(2, 33); put_frame(0, 4, 32'hA1B2C3D4, 0, 0); run_stream(); drain();
    cfg_pre_en = 1'b1; cfg_sync_len = 2'd1; cfg_sync_word = 32'h2DD4; cfg_fix_len = 7'd64;
    idle(3);

    req = "R11";
    fill(64, 5); put_frame(4, 2, 32'h2DD4, 0, 0); run_stream();
    cfg_fix_len = 7'd4; idle(2);
    fill(4, 90); put_frame(4, 2, 32'h2DD4, 0, 0); run_stream();
    drain(); idle(2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule